// File: doc/BRIEF.md
# Shared-Word Descriptor Access Engine

This block serves a 16-bit host that reaches 36-bit storage through a single held descriptor word. The descriptor tells the engine how to treat each host request. It can hand back a constant stored in the descriptor itself. It can reach a 16-bit window at one of four fixed offsets inside a 36-bit word in memory. It can also walk a packed stream of left-justified bytes, each 6, 7, 8, 12 or 16 bits wide. Every write to memory is a read-modify-write, so the bits outside the addressed field keep their values.

The host first loads a descriptor. It then raises `req_valid` with a read or write flag and the write data. The engine answers with a single-cycle `rsp_valid` pulse that carries the read data and two flags: `prot_fault` for a refused write and `wc_overflow` for an exhausted stream. In byte-stream mode the engine writes the advanced position, address and word count back into its descriptor, and the host can watch that state on `desc_out`.

Bits are numbered here with bit 0 as the most significant, so bit k is vector index 35-k. Bits 6-11 hold the selector. Bits 18-35 hold the address in the indirect and stream modes.

The controller is a five-state machine:
- IDLE: waits for a descriptor load or a request.
- FETCH: drives `mem_rd`.
- MERGE: captures `mem_rdata`, extracts the read value and builds the merged word.
- STORE: drives `mem_we` with the merged word.
- DONE: pulses `rsp_valid` and commits the stream advance.

The transitions are:
- IDLE→DONE for an immediate access, a refused write or an exhausted count.
- IDLE→FETCH for any other request.
- FETCH→MERGE always.
- MERGE→STORE on a write.
- MERGE→DONE on a read.
- STORE→DONE always.
- DONE→IDLE always.

Top module: `swd_access`

## Requirements
- R1: The selector in bits 6-11 picks the mode: value 1 is indirect, values 2 to 6 are byte stream, and every other value (including 0, 7 and all unused codes) is immediate.
- R2: An immediate read returns descriptor bits 20-35 with `rsp_valid` one cycle after acceptance and no memory cycle. An immediate write replaces those 16 bits of the held descriptor and returns data 0.
- R3: An indirect read fetches the word at the address field and returns the slice chosen by bits 1-2: 0 gives bits 0-15, 1 gives bits 16-31, 2 gives bits 20-35 and 3 gives bits 2-17. `mem_rd` is high in the first cycle after acceptance and `rsp_valid` is high in the third.
- R4: An indirect write with bit 0 clear stores the 16 host bits into the chosen slice and leaves the other 20 bits unchanged. `mem_we` is high in the third cycle and `rsp_valid` in the fourth.
- R5: An indirect write with bit 0 set makes no memory cycle. It responds one cycle after acceptance with `prot_fault` high and data 0. Reads of such a target proceed normally.
- R6: In stream mode, selector codes 2, 3, 4, 5 and 6 give byte widths 16, 12, 8, 7 and 6. The byte begins at the bit offset held in bits 0-5, and reads return it zero-extended.
- R7: After each stream access the offset advances by the width. When a further byte would not fit within bit 35, the offset returns to 0, the address (bits 18-35) increments and the count (bits 12-17) decrements.
- R8: A stream access while the count is 0 makes no memory cycle. It responds one cycle after acceptance with `wc_overflow` high and data 0, and leaves the descriptor unchanged.
- R9: A stream write stores the low width bits of the host data into the current byte, leaves the other bits unchanged, and returns data 0.
- R10: While busy, requests and descriptor loads are ignored. In IDLE a descriptor load takes precedence over a request raised in the same cycle.
- R11: After reset the engine is idle, all strobes and flags are low, and the held descriptor is 0, which selects immediate mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| desc_load | input | 1 | Load `desc_in` as the held descriptor (IDLE only) |
| desc_in | input | 36 | New descriptor word |
| req_valid | input | 1 | Host access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Host write data |
| busy | output | 1 | Engine not in IDLE |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 16 | Read data, valid with `rsp_valid` |
| prot_fault | output | 1 | Write to a read-only target refused |
| wc_overflow | output | 1 | Stream access with count exhausted |
| desc_out | output | 36 | Current held descriptor |
| mem_rd | output | 1 | Memory read strobe; data is expected one cycle later |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 18 | Memory word address |
| mem_wdata | output | 36 | Merged word to store |
| mem_rdata | input | 36 | Memory read data |

## Verification
The bench builds the engine with the package values: a 36-bit word, a 16-bit host path, a 6-bit count and an 18-bit address. With these values every stream width reaches a word step within a few accesses. A count loaded as 1 runs out after a single word, so overflow appears without long runs. A 64-word bench memory is enough to hold each scenario at its own address, so the read-modify-write results of separate tests never collide.

// File: rtl/swd_pkg.sv
package swd_pkg;
    localparam int WORD_W  = 36;
    localparam int HOST_W  = 16;
    localparam int ADDR_W  = 18;
    localparam int CNT_W   = 6;
    localparam int POS_W   = 6;
    localparam int SEL_W   = 6;
    localparam int OFS_W   = $clog2(WORD_W);
    localparam int WID_W   = $clog2(HOST_W + 1);
    // vector indices (bit 35 is field bit 0)
    localparam int SEL_LSB  = WORD_W - 12;
    localparam int POS_LSB  = WORD_W - POS_W;
    localparam int CNT_LSB  = ADDR_W;
    localparam int ADDR_LSB = 0;

    typedef enum logic [1:0] {MODE_IMM, MODE_IND, MODE_PTR} mode_e;
    typedef enum logic [2:0] {ST_IDLE, ST_FETCH, ST_MERGE, ST_STORE, ST_DONE} state_e;

    typedef struct packed {
        mode_e             mode;
        logic              ro;
        logic [OFS_W-1:0]  lo;
        logic [WID_W-1:0]  width;
        logic [ADDR_W-1:0] addr;
        logic              cnt_zero;
    } dec_t;
endpackage

// File: rtl/swd_decode.sv
module swd_decode
    import swd_pkg::*;
(
    input  logic [WORD_W-1:0] desc,
    output dec_t              dec,
    output logic [WORD_W-1:0] desc_next
);
    localparam logic [POS_W:0] WORD_LEN = (POS_W + 1)'(WORD_W);

    logic [SEL_W-1:0]  sel;
    logic [POS_W-1:0]  pos;
    logic [POS_W-1:0]  pos_eff;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] addr;
    logic [WID_W-1:0]  pwidth;
    logic [1:0]        slice;
    logic [POS_W:0]    wid_x;
    logic [POS_W:0]    pos_nx;
    logic              step;

    assign sel   = desc[SEL_LSB +: SEL_W];
    assign pos   = desc[POS_LSB +: POS_W];
    assign cnt   = desc[CNT_LSB +: CNT_W];
    assign addr  = desc[ADDR_LSB +: ADDR_W];
    assign slice = desc[WORD_W-2 -: 2];

    always_comb begin
        unique case (sel)
            SEL_W'(2): pwidth = WID_W'(16);
            SEL_W'(3): pwidth = WID_W'(12);
            SEL_W'(4): pwidth = WID_W'(8);
            SEL_W'(5): pwidth = WID_W'(7);
            SEL_W'(6): pwidth = WID_W'(6);
            default:   pwidth = WID_W'(HOST_W);
        endcase
    end

    assign wid_x   = (POS_W + 1)'(pwidth);
    assign pos_eff = (({1'b0, pos} + wid_x) > WORD_LEN) ? '0 : pos;
    assign pos_nx  = {1'b0, pos_eff} + wid_x;
    assign step    = (pos_nx + wid_x) > WORD_LEN;

    always_comb begin
        dec          = '0;
        dec.addr     = addr;
        dec.cnt_zero = (cnt == '0);
        dec.width    = WID_W'(HOST_W);
        if (sel == SEL_W'(1)) begin
            dec.mode = MODE_IND;
            dec.ro   = desc[WORD_W-1];
            unique case (slice)
                2'd0: dec.lo = OFS_W'(20);
                2'd1: dec.lo = OFS_W'(4);
                2'd2: dec.lo = OFS_W'(0);
                2'd3: dec.lo = OFS_W'(18);
                default: dec.lo = '0;
            endcase
        end else if (sel >= SEL_W'(2) && sel <= SEL_W'(6)) begin
            dec.mode  = MODE_PTR;
            dec.width = pwidth;
            dec.lo    = OFS_W'(WORD_LEN - {1'b0, pos_eff} - wid_x);
        end else begin
            dec.mode = MODE_IMM;
            dec.lo   = '0;
        end
    end

    always_comb begin
        desc_next = desc;
        if (step) begin
            desc_next[POS_LSB +: POS_W]   = '0;
            desc_next[ADDR_LSB +: ADDR_W] = addr + ADDR_W'(1);
            desc_next[CNT_LSB +: CNT_W]   = cnt - CNT_W'(1);
        end else begin
            desc_next[POS_LSB +: POS_W]   = pos_nx[POS_W-1:0];
        end
    end
endmodule

// File: rtl/swd_lane.sv
module swd_lane
    import swd_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [OFS_W-1:0]  lo,
    input  logic [WID_W-1:0]  width,
    input  logic [HOST_W-1:0] wdata,
    output logic [HOST_W-1:0] rdata,
    output logic [WORD_W-1:0] merged
);
    logic [HOST_W:0]   ones;
    logic [HOST_W-1:0] wmask;
    logic [WORD_W-1:0] shifted;
    logic [WORD_W-1:0] fmask;
    logic [WORD_W-1:0] fdata;

    assign ones    = ((HOST_W + 1)'(1) << width) - (HOST_W + 1)'(1);
    assign wmask   = ones[HOST_W-1:0];
    assign shifted = word >> lo;
    assign rdata   = shifted[HOST_W-1:0] & wmask;
    assign fmask   = WORD_W'(wmask) << lo;
    assign fdata   = WORD_W'(wdata & wmask) << lo;
    assign merged  = (word & ~fmask) | fdata;
endmodule

// File: rtl/swd_access.sv
module swd_access
    import swd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 desc_load,
    input  logic [WORD_W-1:0]    desc_in,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [HOST_W-1:0]    req_wdata,
    output logic                 busy,
    output logic                 rsp_valid,
    output logic [HOST_W-1:0]    rsp_rdata,
    output logic                 prot_fault,
    output logic                 wc_overflow,
    output logic [WORD_W-1:0]    desc_out,
    output logic                 mem_rd,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [WORD_W-1:0]    mem_wdata,
    input  logic [WORD_W-1:0]    mem_rdata
);
    state_e            state_q, state_d;
    logic [WORD_W-1:0] desc_q;
    logic              wr_q;
    logic [HOST_W-1:0] wdata_q;
    logic [WORD_W-1:0] word_q;
    logic [HOST_W-1:0] rdata_q;
    logic              fault_q;
    logic              ovf_q;

    dec_t              dec;
    logic [WORD_W-1:0] desc_next;
    logic [WORD_W-1:0] lane_word;
    logic [HOST_W-1:0] lane_wdata;
    logic [HOST_W-1:0] lane_rdata;
    logic [WORD_W-1:0] lane_merged;
    logic              fault_now;
    logic              ovf_now;
    logic              accept;

    swd_decode u_dec (
        .desc      (desc_q),
        .dec       (dec),
        .desc_next (desc_next)
    );

    assign lane_word  = (dec.mode == MODE_IMM) ? desc_q : mem_rdata;
    assign lane_wdata = (state_q == ST_IDLE) ? req_wdata : wdata_q;

    swd_lane u_lane (
        .word   (lane_word),
        .lo     (dec.lo),
        .width  (dec.width),
        .wdata  (lane_wdata),
        .rdata  (lane_rdata),
        .merged (lane_merged)
    );

    assign accept    = (state_q == ST_IDLE) && req_valid && !desc_load;
    assign fault_now = (dec.mode == MODE_IND) && dec.ro && req_write;
    assign ovf_now   = (dec.mode == MODE_PTR) && dec.cnt_zero;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (dec.mode == MODE_IMM || fault_now || ovf_now) state_d = ST_DONE;
                    else                                              state_d = ST_FETCH;
                end
            end
            ST_FETCH: state_d = ST_MERGE;
            ST_MERGE: state_d = wr_q ? ST_STORE : ST_DONE;
            ST_STORE: state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            desc_q  <= '0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
            word_q  <= '0;
            rdata_q <= '0;
            fault_q <= 1'b0;
            ovf_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (desc_load) begin
                        desc_q <= desc_in;
                    end else if (req_valid) begin
                        wr_q    <= req_write;
                        wdata_q <= req_wdata;
                        fault_q <= fault_now;
                        ovf_q   <= ovf_now;
                        rdata_q <= (dec.mode == MODE_IMM && !req_write) ? lane_rdata : '0;
                        if (dec.mode == MODE_IMM && req_write) desc_q <= lane_merged;
                    end
                end
                ST_MERGE: begin
                    word_q <= lane_merged;
                    if (!wr_q) rdata_q <= lane_rdata;
                end
                ST_DONE: begin
                    if (dec.mode == MODE_PTR && !ovf_q) desc_q <= desc_next;
                    fault_q <= 1'b0;
                    ovf_q   <= 1'b0;
                    rdata_q <= '0;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy        = (state_q != ST_IDLE);
        mem_rd      = (state_q == ST_FETCH);
        mem_we      = (state_q == ST_STORE);
        rsp_valid   = (state_q == ST_DONE);
        mem_addr    = (mem_rd || mem_we) ? dec.addr : '0;
        mem_wdata   = mem_we ? word_q : '0;
        rsp_rdata   = rsp_valid ? rdata_q : '0;
        prot_fault  = rsp_valid && fault_q;
        wc_overflow = rsp_valid && ovf_q;
        desc_out    = desc_q;
    end
endmodule

// File: rtl/swd_access_chk.sv
module swd_access_chk
    import swd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              desc_load,
    input logic              req_valid,
    input logic              busy,
    input logic              rsp_valid,
    input logic [HOST_W-1:0] rsp_rdata,
    input logic              prot_fault,
    input logic              wc_overflow,
    input logic [WORD_W-1:0] desc_out,
    input logic              mem_rd,
    input logic              mem_we
);
    // R2: a response is a single pulse followed by idle
    a_r2_single_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid && !busy);

    // R3: a fetch is one cycle and the engine stays busy after it
    a_r3_fetch_once: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd && busy && !mem_we);

    // R4: a store is immediately followed by a clean response
    a_r4_store_then_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> rsp_valid && !prot_fault && !wc_overflow);

    // R5: a refused write reports through a zero-data response
    a_r5_fault_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        prot_fault |-> rsp_valid && rsp_rdata == '0 && !wc_overflow);

    // R8: an overflow reports through a zero-data response
    a_r8_ovf_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        wc_overflow |-> rsp_valid && rsp_rdata == '0);

    // R10: loads during an access do not touch the descriptor
    a_r10_load_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_load && busy && !rsp_valid) |=> $stable(desc_out));

    // R11: nothing is strobed while idle
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_rd && !mem_we && !rsp_valid);

    // strobes never overlap
    a_r3_strobes_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd, mem_we, rsp_valid}));
endmodule

bind swd_access swd_access_chk u_chk (.*);

// File: tb/swd_access_test.sv
module swd_access_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        desc_load;
    logic [35:0] desc_in;
    logic        req_valid;
    logic        req_write;
    logic [15:0] req_wdata;
    logic        busy;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic        prot_fault;
    logic        wc_overflow;
    logic [35:0] desc_out;
    logic        mem_rd;
    logic        mem_we;
    logic [17:0] mem_addr;
    logic [35:0] mem_wdata;
    logic [35:0] mem_rdata;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    logic [35:0] mem     [0:63];
    logic [35:0] ref_mem [0:63];
    logic [35:0] ref_desc;

    always #5 clk = ~clk;

    swd_access uut (.*);

    function automatic logic [35:0] seedw(input int i);
        return (36'(i) * 36'd97001) ^ 36'hA5F03C961;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mem[i] <= seedw(i);
            mem_rdata <= '0;
        end else begin
            if (mem_rd) mem_rdata <= mem[mem_addr[5:0]];
            if (mem_we) mem[mem_addr[5:0]] <= mem_wdata;
        end
    end

    // field helpers, bit 0 = most significant
    function automatic logic [35:0] getf(input logic [35:0] w, input int first, input int n);
        logic [35:0] v = '0;
        for (int i = 0; i < n; i++) v = {v[34:0], w[35-(first+i)]};
        return v;
    endfunction

    function automatic logic [35:0] putf(input logic [35:0] w, input int first, input int n,
                                         input logic [35:0] v);
        logic [35:0] r = w;
        for (int i = 0; i < n; i++) r[35-(first+i)] = v[n-1-i];
        return r;
    endfunction

    function automatic logic [35:0] mk_imm(input int sel, input logic [15:0] data);
        return putf(putf(putf(36'd0, 0, 6, 36'h2B), 6, 6, 36'(sel)), 20, 16, 36'(data));
    endfunction

    function automatic logic [35:0] mk_ind(input int ro, input int p, input int addr);
        logic [35:0] d = '0;
        d = putf(d, 0, 1, 36'(ro));
        d = putf(d, 1, 2, 36'(p));
        d = putf(d, 6, 6, 36'd1);
        return putf(d, 18, 18, 36'(addr));
    endfunction

    function automatic logic [35:0] mk_ptr(input int pos, input int code, input int cnt, input int addr);
        logic [35:0] d = '0;
        d = putf(d, 0, 6, 36'(pos));
        d = putf(d, 6, 6, 36'(code));
        d = putf(d, 12, 6, 36'(cnt));
        return putf(d, 18, 18, 36'(addr));
    endfunction

    function automatic int code_width(input int code);
        case (code)
            2: return 16;
            3: return 12;
            4: return 8;
            5: return 7;
            default: return 6;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load(input logic [35:0] d);
        desc_load = 1'b1;
        desc_in   = d;
        @(negedge clk);
        desc_load = 1'b0;
        ref_desc  = d;
    endtask

    // behavioural model plus cycle-by-cycle comparison
    task automatic access(input string tag, input logic wr, input logic [15:0] wd, input bit poke);
        int sel, lat, start, width, pos, cnt, addr, ma;
        bit touches, fault, ovf;
        logic [15:0] exp_d;
        sel = int'(getf(ref_desc, 6, 6));
        addr = int'(getf(ref_desc, 18, 18));
        ma = addr & 63;
        touches = 0; fault = 0; ovf = 0; exp_d = '0; lat = 1;
        if (sel == 1) begin
            case (int'(getf(ref_desc, 1, 2)))
                0: start = 0;
                1: start = 16;
                2: start = 20;
                default: start = 2;
            endcase
            if (wr && getf(ref_desc, 0, 1) == 36'd1) fault = 1;
            else begin
                touches = 1;
                lat = wr ? 4 : 3;
                if (!wr) exp_d = 16'(getf(ref_mem[ma], start, 16));
                else ref_mem[ma] = putf(ref_mem[ma], start, 16, 36'(wd));
            end
        end else if (sel >= 2 && sel <= 6) begin
            width = code_width(sel);
            pos = int'(getf(ref_desc, 0, 6));
            if (pos + width > 36) pos = 0;
            cnt = int'(getf(ref_desc, 12, 6));
            if (cnt == 0) ovf = 1;
            else begin
                touches = 1;
                lat = wr ? 4 : 3;
                if (!wr) exp_d = 16'(getf(ref_mem[ma], pos, width));
                else ref_mem[ma] = putf(ref_mem[ma], pos, width, 36'(wd) & ((36'd1 << width) - 36'd1));
                pos = pos + width;
                if (pos + width > 36) begin
                    pos = 0; addr = addr + 1; cnt = cnt - 1;
                end
                ref_desc = putf(putf(putf(ref_desc, 0, 6, 36'(pos)), 12, 6, 36'(cnt)), 18, 18, 36'(addr));
            end
        end else begin
            if (!wr) exp_d = 16'(getf(ref_desc, 20, 16));
            else ref_desc = putf(ref_desc, 20, 16, 36'(wd));
        end

        req_valid = 1'b1;
        req_write = wr;
        req_wdata = wd;
        @(posedge clk);
        for (int k = 1; k <= lat; k++) begin
            @(negedge clk);
            if (k == 1) begin
                req_valid = 1'b0;
                if (poke) begin
                    desc_load = 1'b1;
                    desc_in   = 36'hFFFFFFFFF;
                    req_valid = 1'b1;
                end
            end
            if (k == 2) begin
                desc_load = 1'b0;
                req_valid = 1'b0;
            end
            chk({tag, " rsp_valid"}, 36'(rsp_valid), 36'(k == lat));
            chk({tag, " mem_rd"},    36'(mem_rd),    36'(touches && k == 1));
            chk({tag, " mem_we"},    36'(mem_we),    36'(touches && wr && k == lat - 1));
            if (k == lat) begin
                chk({tag, " data"},     36'(rsp_rdata),   36'(exp_d));
                chk({tag, " fault"},    36'(prot_fault),  36'(fault));
                chk({tag, " overflow"}, 36'(wc_overflow), 36'(ovf));
            end
        end
        @(negedge clk);
        chk({tag, " descriptor"}, desc_out, ref_desc);
        if (touches && wr) chk({tag, " memory word"}, mem[ma], ref_mem[ma]);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        for (int i = 0; i < 64; i++) ref_mem[i] = seedw(i);
        ref_desc  = '0;
        rst_n     = 1'b0;
        desc_load = 1'b0;
        desc_in   = '0;
        req_valid = 1'b0;
        req_write = 1'b0;
        req_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk("R11 busy",      36'(busy),        36'd0);
        chk("R11 rsp_valid", 36'(rsp_valid),   36'd0);
        chk("R11 strobes",   36'({mem_rd, mem_we, prot_fault, wc_overflow}), 36'd0);
        chk("R11 descriptor", desc_out, 36'd0);
        access("R11 immediate after reset", 1'b0, 16'h0, 0);

        // R1 / R2 immediate
        load(mk_imm(0, 16'h1234));
        access("R2 imm code0 read", 1'b0, 16'h0, 0);
        load(mk_imm(7, 16'hBEEF));
        access("R2 imm code7 read", 1'b0, 16'h0, 0);
        load(mk_imm(9, 16'h0F0F));
        access("R1 unused code9 read", 1'b0, 16'h0, 0);
        load(mk_imm(63, 16'h8001));
        access("R1 unused code63 read", 1'b0, 16'h0, 0);
        access("R2 imm write", 1'b1, 16'h5A5A, 0);
        access("R2 imm read back", 1'b0, 16'h0, 0);

        // R3 / R4 indirect slices
        for (int p = 0; p < 4; p++) begin
            load(mk_ind(0, p, 5));
            access("R3 ind slice read", 1'b0, 16'h0, 0);
        end
        for (int p = 0; p < 4; p++) begin
            load(mk_ind(0, p, 6 + p));
            access("R4 ind slice write", 1'b1, 16'hC3A5 ^ 16'(p * 16'h1111), 0);
            access("R4 ind slice read back", 1'b0, 16'h0, 0);
        end

        // R5 read-only target
        load(mk_ind(1, 2, 12));
        access("R5 ro write refused", 1'b1, 16'hFFFF, 0);
        access("R5 ro read allowed", 1'b0, 16'h0, 0);

        // R10 busy ignores load and request
        load(mk_ind(0, 1, 13));
        access("R10 ignored while busy", 1'b0, 16'h0, 1);
        desc_load = 1'b1; desc_in = mk_imm(0, 16'h7777); req_valid = 1'b1; req_write = 1'b0;
        @(negedge clk);
        desc_load = 1'b0; req_valid = 1'b0; ref_desc = mk_imm(0, 16'h7777);
        chk("R10 load wins in idle rsp", 36'(rsp_valid), 36'd0);
        chk("R10 load wins in idle desc", desc_out, ref_desc);

        // R6 / R7 stream reads across a word boundary
        for (int code = 2; code <= 6; code++) begin
            n = 36 / code_width(code);
            load(mk_ptr(0, code, 2, 20 + code));
            for (int b = 0; b <= n; b++) access("R6 R7 stream read", 1'b0, 16'h0, 0);
        end
        load(mk_ptr(12, 3, 1, 27));
        access("R6 mid-word start", 1'b0, 16'h0, 0);

        // R9 stream writes then read back
        for (int code = 2; code <= 6; code++) begin
            n = 36 / code_width(code);
            load(mk_ptr(0, code, 2, 30 + 2 * code));
            for (int b = 0; b <= n; b++) access("R9 stream write", 1'b1, 16'hFFFF - 16'(b * 16'h0123), 0);
            load(mk_ptr(0, code, 2, 30 + 2 * code));
            for (int b = 0; b <= n; b++) access("R9 stream read back", 1'b0, 16'h0, 0);
        end

        // R8 count exhaustion
        load(mk_ptr(0, 4, 1, 50));
        for (int b = 0; b < 4; b++) access("R8 last word", 1'b0, 16'h0, 0);
        access("R8 overflow read", 1'b0, 16'h0, 0);
        access("R8 overflow write", 1'b1, 16'h1234, 0);
        chk("R8 neighbour untouched", mem[51], ref_mem[51]);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule